// File: doc/BRIEF.md
# Barrel Thread Issue Scheduler

This block picks, in every core cycle, which hardware thread context of a barrel-style multithreaded core may issue an instruction. Threads are served round robin in increasing index order, so a thread issues once per round. A round is never shorter than four cycles. When fewer than four threads are active, the remaining slots of the round are empty bubbles. With five or more active threads, a round lasts exactly as many cycles as there are active threads, with no bubbles.

A free-running reference timer advances once every fourth core cycle. Because a round of five to seven cycles does not divide evenly into four, the number of timer ticks a thread observes between two of its own issues alternates between one and two, depending on the phase of the issue cycle against the timer prescaler. With four or fewer threads that count is always one, and with eight threads it is always two.

The active mask is sampled only at a round boundary (the wrap), so a mask change never makes a thread issue twice inside one round. The control is a three-state machine. ST_IDLE: no thread is active, and the mask is sampled every cycle. ST_ISSUE: the lowest thread still pending in the round issues. ST_PAD: bubble slots fill the round up to four cycles. The transitions are as follows. IDLE to ISSUE happens when the sampled mask is non-zero, and IDLE to IDLE when it is zero. ISSUE to ISSUE happens while threads are still pending in the round. ISSUE to PAD happens after the last issue of a round with fewer than four threads. ISSUE ends at a wrap after the last issue of a round with four or more threads. PAD to PAD happens while bubbles remain. PAD ends at a wrap after the last bubble. At a wrap the next state is ISSUE if the newly sampled mask is non-zero, and IDLE otherwise.

Top module: `barrel_issue_sched`

## Requirements
- R1: While reset is asserted, and in the first cycle after it is released, valid is 0, the grant is all zero and the timer reads 0.
- R2: Only threads in the current round's mask issue. Successive issues follow increasing thread index and wrap to the lowest active index, and every active thread issues within each round.
- R3: With one to four active threads, each active thread issues exactly once every 4 cycles. In the other slots, valid is 0 and the grant is 0.
- R4: With N active threads, where N is 5 to 8, each thread issues exactly once every N cycles.
- R5: The timer reads floor(k/4) in the k-th cycle after reset release. It is 32 bits wide and wraps modulo 2^32.
- R6: Let an issue at cycle c be followed by the same thread's next issue at cycle c+P. The timer difference between the two is floor((c+P)/4) - floor(c/4). This equals 1 for four or fewer threads and 2 for eight threads, and takes both the value 1 and the value 2 for five to seven threads.
- R7: A change of the active mask takes effect only at the next round wrap. The current round finishes with its old membership, and no thread issues twice in a round.
- R8: When no thread is active, valid stays 0 and the grant stays 0.
- R9: When valid is 1, the grant has exactly one bit set, and the index output equals that bit's position.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Core clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| active_i | input | NUM_THREADS | Per-thread active mask, bit i = thread i |
| grant_o | output | NUM_THREADS | One-hot issue grant for this cycle |
| issue_idx_o | output | IDX_W | Index of the issuing thread |
| valid_o | output | 1 | An issue happens this cycle |
| timer_o | output | TIMER_W | Reference timer, one step per four cycles |

## Verification
The mask re-sample at a round wrap and an external mask change can fall in the same stretch of cycles. The bench provokes this by shrinking the mask from all eight threads to two, right after thread 2 issues. It then judges that threads 3 to 7 still issue before the new two-thread round starts. The other overlap is a timer tick falling on an issue cycle. Every issue's timer reading is compared against the tick count derived from the bench's own cycle number, and for five to seven threads both one-tick and two-tick spacings must be seen.

// File: rtl/bis_pkg.sv
package bis_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ISSUE = 2'd1,
        ST_PAD   = 2'd2
    } sched_state_e;
endpackage

// File: rtl/bis_lowest.sv
module bis_lowest #(
    parameter int WIDTH = 8,
    localparam int IDX_W = (WIDTH > 1) ? $clog2(WIDTH) : 1
) (
    input  logic [WIDTH-1:0] vec_i,
    output logic [WIDTH-1:0] onehot_o,
    output logic [IDX_W-1:0] idx_o
);
    logic found;

    always_comb begin
        onehot_o = '0;
        idx_o    = '0;
        found    = 1'b0;
        for (int i = 0; i < WIDTH; i++) begin
            if (vec_i[i] && !found) begin
                onehot_o[i] = 1'b1;
                idx_o       = IDX_W'(i);
                found       = 1'b1;
            end
        end
    end
endmodule

// File: rtl/bis_popcount.sv
module bis_popcount #(
    parameter int WIDTH = 8,
    localparam int CNT_W = $clog2(WIDTH + 1)
) (
    input  logic [WIDTH-1:0] vec_i,
    output logic [CNT_W-1:0] count_o
);
    always_comb begin
        count_o = '0;
        for (int i = 0; i < WIDTH; i++) begin
            count_o = count_o + CNT_W'(vec_i[i]);
        end
    end
endmodule

// File: rtl/bis_reftimer.sv
module bis_reftimer #(
    parameter int TIMER_W = 32,
    parameter int DIV     = 4,
    localparam int PRE_W  = (DIV > 1) ? $clog2(DIV) : 1
) (
    input  logic               clk_i,
    input  logic               rst_ni,
    output logic [TIMER_W-1:0] timer_o
);
    logic [PRE_W-1:0]   pre_q;
    logic [TIMER_W-1:0] timer_q;
    logic               tick;

    assign tick = (pre_q == PRE_W'(DIV - 1));

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            pre_q   <= '0;
            timer_q <= '0;
        end else begin
            pre_q <= tick ? '0 : pre_q + 1'b1;
            if (tick) begin
                timer_q <= timer_q + 1'b1;
            end
        end
    end

    assign timer_o = timer_q;

    // R5: the timer steps by one right after the prescaler's last phase
    a_r5_timer_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (pre_q == PRE_W'(DIV - 1)) |=> (timer_o == $past(timer_o) + 1'b1));

    // R5: the timer holds in every other phase
    a_r5_timer_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (pre_q != PRE_W'(DIV - 1)) |=> $stable(timer_o));
endmodule

// File: rtl/barrel_issue_sched.sv
module barrel_issue_sched
    import bis_pkg::*;
#(
    parameter int NUM_THREADS = 8,
    parameter int MIN_GAP     = 4,
    parameter int TIMER_W     = 32,
    localparam int IDX_W      = (NUM_THREADS > 1) ? $clog2(NUM_THREADS) : 1,
    localparam int CNT_W      = $clog2(NUM_THREADS + 1),
    localparam int PAD_W      = $clog2(MIN_GAP + 1)
) (
    input  logic                   clk_i,
    input  logic                   rst_ni,
    input  logic [NUM_THREADS-1:0] active_i,
    output logic [NUM_THREADS-1:0] grant_o,
    output logic [IDX_W-1:0]       issue_idx_o,
    output logic                   valid_o,
    output logic [TIMER_W-1:0]     timer_o
);
    sched_state_e           state_q, state_d;
    logic [NUM_THREADS-1:0] pend_q, pend_d;
    logic [NUM_THREADS-1:0] round_q, round_d;
    logic [CNT_W-1:0]       cnt_q, cnt_d;
    logic [PAD_W-1:0]       pad_q, pad_d;
    logic [NUM_THREADS-1:0] pick_oh;
    logic [IDX_W-1:0]       pick_idx;
    logic [CNT_W-1:0]       act_cnt;
    logic                   wrap;

    bis_lowest #(.WIDTH(NUM_THREADS)) u_pick (
        .vec_i    (pend_q),
        .onehot_o (pick_oh),
        .idx_o    (pick_idx)
    );

    bis_popcount #(.WIDTH(NUM_THREADS)) u_count (
        .vec_i   (active_i),
        .count_o (act_cnt)
    );

    bis_reftimer #(.TIMER_W(TIMER_W), .DIV(MIN_GAP)) u_timer (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .timer_o (timer_o)
    );

    // state register
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            state_q <= ST_IDLE;
            pend_q  <= '0;
            round_q <= '0;
            cnt_q   <= '0;
            pad_q   <= '0;
        end else begin
            state_q <= state_d;
            pend_q  <= pend_d;
            round_q <= round_d;
            cnt_q   <= cnt_d;
            pad_q   <= pad_d;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        pend_d  = pend_q;
        round_d = round_q;
        cnt_d   = cnt_q;
        pad_d   = pad_q;
        wrap    = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                wrap = 1'b1;
            end
            ST_ISSUE: begin
                pend_d = pend_q & ~pick_oh;
                if (pend_d == '0) begin
                    if (cnt_q < CNT_W'(MIN_GAP)) begin
                        state_d = ST_PAD;
                        pad_d   = PAD_W'(MIN_GAP) - PAD_W'(cnt_q);
                    end else begin
                        wrap = 1'b1;
                    end
                end
            end
            ST_PAD: begin
                if (pad_q <= PAD_W'(1)) begin
                    wrap = 1'b1;
                end else begin
                    pad_d = pad_q - 1'b1;
                end
            end
            default: begin
                state_d = ST_IDLE;
            end
        endcase
        if (wrap) begin
            round_d = active_i;
            pend_d  = active_i;
            cnt_d   = act_cnt;
            pad_d   = '0;
            state_d = (active_i != '0) ? ST_ISSUE : ST_IDLE;
        end
    end

    // outputs
    always_comb begin
        valid_o     = (state_q == ST_ISSUE);
        grant_o     = valid_o ? pick_oh : '0;
        issue_idx_o = pick_idx;
    end

    // R9: at most one grant bit, and the index points at it
    a_r9_onehot: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $onehot0(grant_o));
    a_r9_idx_match: assert property (@(posedge clk_i) disable iff (!rst_ni)
        valid_o |-> grant_o[issue_idx_o]);

    // R7: grants stay inside the mask latched at the last wrap
    a_r7_member: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (grant_o & ~round_q) == '0);

    // R7: a granted thread is not pending again until the round wraps
    a_r7_no_repeat: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (valid_o && (state_d == ST_ISSUE) && !wrap) |=> ((pend_q & $past(grant_o)) == '0));

    // R8: an empty mask seen in idle keeps the next cycle silent
    a_r8_idle_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ((state_q == ST_IDLE) && (active_i == '0)) |=> (!valid_o && grant_o == '0));

    // R3: a bubble slot carries no issue
    a_r3_pad_bubble: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state_q == ST_PAD) |-> (grant_o == '0));
endmodule

// File: tb/sim_barrel_issue_sched.sv
module sim_barrel_issue_sched;
    logic        clk;
    logic        rst_n;
    logic [7:0]  active;
    logic [7:0]  grant;
    logic [2:0]  idx;
    logic        valid;
    logic [31:0] timer;
    int          cyc;
    int          n_chk;
    int          n_fail;
    bit          done;

    barrel_issue_sched #(.NUM_THREADS(8), .MIN_GAP(4), .TIMER_W(32)) u0 (
        .clk_i       (clk),
        .rst_ni      (rst_n),
        .active_i    (active),
        .grant_o     (grant),
        .issue_idx_o (idx),
        .valid_o     (valid),
        .timer_o     (timer)
    );

    initial clk = 1'b0;
    always #5 clk = ~clk;

    always @(posedge clk) begin
        if (!rst_n) cyc <= 0;
        else        cyc <= cyc + 1;
    end

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    function automatic int pop8(input logic [7:0] m);
        int c = 0;
        for (int i = 0; i < 8; i++) c += int'(m[i]);
        return c;
    endfunction

    function automatic int next_idx(input logic [7:0] m, input int p);
        for (int k = 1; k <= 8; k++) begin
            if (m[(p + k) % 8]) return (p + k) % 8;
        end
        return -1;
    endfunction

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    endtask

    // R1: reset state
    task automatic t_reset();
        active = 8'h00;
        rst_n  = 1'b0;
        repeat (3) @(negedge clk);
        chk(valid == 1'b0, "R1 valid in reset", valid, 0);
        chk(grant == 8'h00, "R1 grant in reset", grant, 0);
        chk(timer == 32'd0, "R1 timer in reset", timer, 0);
        rst_n = 1'b1;
        #1;
        chk(valid == 1'b0 && grant == 8'h00, "R1 after release", grant, 0);
        chk(timer == 32'd0, "R1 timer after release", timer, 0);
    endtask

    // R2 R3 R4 R5 R6 R9: steady schedule for one mask
    task automatic t_measure(input logic [7:0] m);
        int n      = pop8(m);
        int period = (n <= 4) ? 4 : n;
        int last_c[8];
        longint last_t[8];
        bit seen[8];
        int prev = -1;
        int d1 = 0;
        int d2 = 0;
        @(negedge clk);
        active = m;
        repeat (20) @(negedge clk);
        for (int i = 0; i < 8; i++) seen[i] = 1'b0;
        for (int s = 0; s < 48; s++) begin
            @(negedge clk);
            chk(timer == 32'(cyc >> 2), "R5 timer value", timer, cyc >> 2);
            if (valid) begin
                int k = int'(idx);
                chk(grant == 8'(1 << k), "R9 grant vs index", grant, 1 << k);
                chk(m[k] == 1'b1, "R2 member only", k, -1);
                if (prev >= 0)
                    chk(k == next_idx(m, prev), "R2 round-robin order", k, next_idx(m, prev));
                if (seen[k]) begin
                    longint dt  = longint'(timer) - last_t[k];
                    longint edt = longint'((cyc >> 2) - (last_c[k] >> 2));
                    if (n <= 4) chk(cyc - last_c[k] == 4, "R3 spacing", cyc - last_c[k], 4);
                    else        chk(cyc - last_c[k] == n, "R4 spacing", cyc - last_c[k], n);
                    chk(dt == edt, "R6 tick delta by phase", dt, edt);
                    if (n <= 4)      chk(dt == 1, "R6 delta low count", dt, 1);
                    else if (n == 8) chk(dt == 2, "R6 delta full count", dt, 2);
                    if (dt == 1) d1++;
                    if (dt == 2) d2++;
                end
                seen[k]   = 1'b1;
                last_c[k] = cyc;
                last_t[k] = longint'(timer);
                prev      = k;
            end else begin
                chk(grant == 8'h00, "R3 bubble has no grant", grant, 0);
            end
        end
        for (int i = 0; i < 8; i++)
            chk(seen[i] == m[i], "R2 every active thread served", seen[i], m[i]);
        if (n >= 5 && n <= 7)
            chk(d1 > 0 && d2 > 0, "R6 both deltas seen", d1 * 100 + d2, 1);
    endtask

    // R7: mask shrinks mid-round
    task automatic t_mask_change();
        int want[7] = '{3, 4, 5, 6, 7, 0, 1};
        int got = 0;
        @(negedge clk);
        active = 8'hFF;
        repeat (20) @(negedge clk);
        while (!(valid && idx == 3'd2)) @(negedge clk);
        active = 8'h03;
        while (got < 7) begin
            @(negedge clk);
            if (valid) begin
                chk(int'(idx) == want[got], "R7 old round completes", idx, want[got]);
                got++;
            end
        end
        repeat (2) @(negedge clk);
        chk(valid == 1'b0, "R7 new round padded", valid, 0);
    endtask

    // R8: empty mask
    task automatic t_empty();
        @(negedge clk);
        active = 8'h00;
        repeat (10) @(negedge clk);
        for (int s = 0; s < 8; s++) begin
            @(negedge clk);
            chk(valid == 1'b0 && grant == 8'h00, "R8 idle silent", grant, 0);
        end
    endtask

    initial begin
        n_chk  = 0;
        n_fail = 0;
        done   = 1'b0;
        rst_n  = 1'b0;
        active = 8'h00;
        t_reset();
        repeat (6) @(negedge clk);
        chk(valid == 1'b0, "R8 no thread after reset", valid, 0);
        for (int n = 1; n <= 8; n++) t_measure(8'((1 << n) - 1));
        t_measure(8'h81);
        t_measure(8'h5A);
        t_measure(8'hB7);
        t_measure(8'hF8);
        t_mask_change();
        t_empty();
        t_measure(8'h40);
        finish_run();
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
        finish_run();
    end
endmodule